// File: doc/BRIEF.md
# Interrupt Pending-State Register Bank

This block holds the pending and active state of a group of interrupt lines and gives software a 32-bit register port to inspect and change that state. Each line can be edge- or level-triggered, as chosen per interrupt. An edge-triggered line latches pending on the rising edge of its synchronized input. A level-triggered line is pending while its input is high, or while a software set request is latched.

Software sees two register windows that carry the same bit layout. A write to the set window marks interrupts pending. A write to the clear window removes pending state with write-one-to-clear semantics. A read of either window returns the current pending view. Per-interrupt acknowledge and end-of-interrupt inputs move interrupts into and out of the active state, so the active-and-pending combinations can be reached. Every bus access carries a non-secure attribute. When security is enabled, that attribute hides secure-group interrupts unless a per-interrupt permission bit opens them. The lowest identifiers are software-generated interrupts. Their bits can be read but ignore writes.

Top module: `irq_pend_bank`

## Requirements
- R1: Interrupt m sits in register m/32 at bit m mod 32. Register n of the set window is at byte address SET_BASE+4n and register n of the clear window is at CLR_BASE+4n. A read of either window returns the same pending view.
- R2: A read bit is 1 when the interrupt is pending or active-and-pending. It is 0 when the interrupt is inactive or only active.
- R3: Writing 1 to a clear-window bit takes a pending interrupt to inactive and an active-and-pending interrupt to active. A 0 bit has no effect, and a 1 written to an interrupt that is not pending changes nothing, including its active state.
- R4: For a level-triggered interrupt, a clear removes only the pending state latched by a set write. While the synchronized input stays high the interrupt stays pending, and it stops being pending once the input is low and nothing is latched.
- R5: An edge-triggered interrupt becomes pending on a rising edge of its input after SYNC_STAGES synchronizer flops, and stays pending after the input falls.
- R6: Interrupts 0 to SGI_NUM-1 read their pending state, but set and clear writes to their bits are ignored.
- R7: Bits for identifiers at or above NUM_IRQ, registers with an index at or above REGS_M1+1, and all addresses outside both windows read as zero and ignore writes.
- R8: When sec_en is 1 and an access has bus_ns=1, the bits of interrupts with irq_secure_grp=1 and irq_ns_allow=0 read as zero and ignore writes. With sec_en=0, or with permission granted, such accesses act normally.
- R9: An ack pulse on a pending, non-active interrupt makes it active and removes its latched pending state. An eoi pulse on an active interrupt makes it inactive.
- R10: After reset, all pending latches and active flags are 0 and every register reads zero.
- R11: Writing 1 to a set-window bit latches pending for either trigger mode, and a set request or a new edge wins over a clear or ack in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_line | input | NUM_IRQ | Raw interrupt inputs |
| irq_edge_cfg | input | NUM_IRQ | 1 = edge-triggered, 0 = level-triggered |
| irq_secure_grp | input | NUM_IRQ | 1 = interrupt belongs to a secure group |
| irq_ns_allow | input | NUM_IRQ | 1 = non-secure accesses may use this secure interrupt |
| sec_en | input | 1 | Security gating enabled |
| ack | input | NUM_IRQ | Acknowledge pulse per interrupt |
| eoi | input | NUM_IRQ | End-of-interrupt pulse per interrupt |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_ns | input | 1 | Access is non-secure |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pend_o | output | NUM_IRQ | Per-interrupt pending state |
| active_o | output | NUM_IRQ | Per-interrupt active state |

## Verification
Every implemented identifier in turn gets an isolated edge pulse followed by a single-bit clear. This separates the mapping of each identifier, the read-only software-generated range and the ordinary clearable range. Full-word set and clear writes with zero, partial and all-ones masks show that zero bits are ignored and that unimplemented bits stay zero. A level-triggered line is driven with the input high, with a latched set request, and with both. This tells a clear that removes only the latch apart from one that wrongly drops a still-asserted line. Ack and eoi sequences combined with secure and non-secure accesses, with and without permission and with security on and off, reach the active-only and active-and-pending states and show the gating of reads and writes.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

   // Which register window a decoded access falls in
   typedef enum logic [1:0] {
      WIN_NONE = 2'd0,
      WIN_SET  = 2'd1,
      WIN_CLR  = 2'd2
   } win_e;

   // Number of index bits needed for a given register count
   function automatic int idx_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/irqp_sync.sv
module irqp_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] line_i,
   output logic [W-1:0] sync_o,
   output logic [W-1:0] rise_o
);

   logic [W-1:0] stg [STAGES];
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg[k] <= '0;
         prev_q <= '0;
      end else begin
         stg[0] <= line_i;
         for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
         prev_q <= stg[STAGES-1];
      end
   end

   assign sync_o = stg[STAGES-1];
   assign rise_o = stg[STAGES-1] & ~prev_q;

   // R5: a detected edge lasts exactly one cycle
   assert_rise_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));

endmodule

// File: rtl/irqp_decode.sv
module irqp_decode
   import irqp_pkg::*;
#(
   parameter int          ADDR_W   = 12,
   parameter int          NREG     = 2,
   parameter int unsigned SET_BASE = 32'h100,
   parameter int unsigned CLR_BASE = 32'h180,
   localparam int         IDX_W    = idx_bits(NREG)
) (
   input  logic [ADDR_W-1:0] addr_i,
   output win_e              win_o,
   output logic [IDX_W-1:0]  idx_o
);

   localparam logic [ADDR_W-1:0]   SB   = ADDR_W'(SET_BASE);
   localparam logic [ADDR_W-1:0]   CB   = ADDR_W'(CLR_BASE);
   localparam logic [ADDR_W-3:0]   NLIM = (ADDR_W-2)'(NREG);

   logic [ADDR_W-1:0] d_set, d_clr;
   logic              in_set, in_clr;

   assign d_set  = addr_i - SB;
   assign d_clr  = addr_i - CB;
   assign in_set = (addr_i >= SB) && (d_set[ADDR_W-1:2] < NLIM);
   assign in_clr = (addr_i >= CB) && (d_clr[ADDR_W-1:2] < NLIM);

   always_comb begin
      win_o = WIN_NONE;
      idx_o = '0;
      if (in_set) begin
         win_o = WIN_SET;
         idx_o = d_set[2 +: IDX_W];
      end else if (in_clr) begin
         win_o = WIN_CLR;
         idx_o = d_clr[2 +: IDX_W];
      end
   end

endmodule

// File: rtl/irqp_gate.sv
module irqp_gate #(
   parameter int N       = 48,
   parameter int SGI_NUM = 16
) (
   input  logic         sec_en,
   input  logic         bus_ns,
   input  logic [N-1:0] secure_grp,
   input  logic [N-1:0] ns_allow,
   output logic [N-1:0] rd_ok,
   output logic [N-1:0] wr_ok
);

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic blocked;
      assign blocked  = sec_en & bus_ns & secure_grp[i] & ~ns_allow[i];
      assign rd_ok[i] = ~blocked;
      if (i < SGI_NUM) begin : g_sgi
         assign wr_ok[i] = 1'b0;
      end else begin : g_std
         assign wr_ok[i] = ~blocked;
      end
   end

endmodule

// File: rtl/irqp_cell.sv
module irqp_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_line,
   input  logic rise,
   input  logic edge_mode,
   input  logic set_stb,
   input  logic clr_stb,
   input  logic ack,
   input  logic eoi,
   output logic pend,
   output logic active
);

   logic latch_q, latch_n, active_n, take;

   assign pend = latch_q | (~edge_mode & sync_line);
   assign take = ack & pend & ~active;

   always_comb begin
      latch_n = latch_q;
      if (clr_stb) latch_n = 1'b0;
      if (take)    latch_n = 1'b0;
      if (set_stb | (edge_mode & rise)) latch_n = 1'b1;
   end

   always_comb begin
      active_n = active;
      if (take)               active_n = 1'b1;
      else if (eoi & active)  active_n = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= 1'b0;
         active  <= 1'b0;
      end else begin
         latch_q <= latch_n;
         active  <= active_n;
      end
   end

   // R3: a clear with no competing set leaves no latched pending state
   assert_clr_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_stb && !set_stb && !(edge_mode && rise)) |=> !latch_q);

   // R11: a set request always leaves the latch set
   assert_set_latches_R11: assert property (@(posedge clk) disable iff (!rst_n)
      set_stb |=> latch_q);

   // R9: acknowledge of a pending inactive interrupt activates it
   assert_ack_activates_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && pend && !active) |=> active);

   // R9: end-of-interrupt returns an active interrupt to inactive
   assert_eoi_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && active) |=> !active);

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
   import irqp_pkg::*;
#(
   parameter int          REGS_M1     = 1,
   parameter int          NUM_IRQ     = 48,
   parameter int          SGI_NUM     = 16,
   parameter int          SYNC_STAGES = 2,
   parameter int          ADDR_W      = 12,
   parameter int unsigned SET_BASE    = 32'h100,
   parameter int unsigned CLR_BASE    = 32'h180
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] irq_line,
   input  logic [NUM_IRQ-1:0] irq_edge_cfg,
   input  logic [NUM_IRQ-1:0] irq_secure_grp,
   input  logic [NUM_IRQ-1:0] irq_ns_allow,
   input  logic               sec_en,
   input  logic [NUM_IRQ-1:0] ack,
   input  logic [NUM_IRQ-1:0] eoi,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   input  logic               bus_ns,
   output logic [31:0]        bus_rdata,
   output logic [NUM_IRQ-1:0] pend_o,
   output logic [NUM_IRQ-1:0] active_o
);

   localparam int NREG  = REGS_M1 + 1;
   localparam int NBIT  = 32 * NREG;
   localparam int IDX_W = idx_bits(NREG);

   // Elaboration-time parameter checks
   if (NUM_IRQ > NBIT || NUM_IRQ <= SGI_NUM) begin : g_chk_count
      $error("irq_pend_bank: NUM_IRQ must exceed SGI_NUM and fit the register count");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("irq_pend_bank: SYNC_STAGES must be at least 2");
   end
   if ((SET_BASE % 4) != 0 || (CLR_BASE % 4) != 0) begin : g_chk_align
      $error("irq_pend_bank: window bases must be word aligned");
   end
   if (!((SET_BASE + 4*NREG <= CLR_BASE) || (CLR_BASE + 4*NREG <= SET_BASE))) begin : g_chk_ovl
      $error("irq_pend_bank: set and clear windows overlap");
   end
   if ((CLR_BASE + 4*NREG > (1 << ADDR_W)) || (SET_BASE + 4*NREG > (1 << ADDR_W))) begin : g_chk_span
      $error("irq_pend_bank: windows exceed the address space");
   end

   // Input synchronization and edge detection
   logic [NUM_IRQ-1:0] line_s, line_rise;

   irqp_sync #(.W(NUM_IRQ), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (irq_line),
      .sync_o (line_s),
      .rise_o (line_rise)
   );

   // Address decode
   win_e             dec_win;
   logic [IDX_W-1:0] dec_idx;
   logic             dec_hit;

   irqp_decode #(
      .ADDR_W(ADDR_W), .NREG(NREG), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
   ) u_dec (
      .addr_i (bus_addr),
      .win_o  (dec_win),
      .idx_o  (dec_idx)
   );

   assign dec_hit = (dec_win != WIN_NONE);

   // Access gating per interrupt
   logic [NUM_IRQ-1:0] rd_ok, wr_ok;

   irqp_gate #(.N(NUM_IRQ), .SGI_NUM(SGI_NUM)) u_gate (
      .sec_en     (sec_en),
      .bus_ns     (bus_ns),
      .secure_grp (irq_secure_grp),
      .ns_allow   (irq_ns_allow),
      .rd_ok      (rd_ok),
      .wr_ok      (wr_ok)
   );

   // Per-interrupt state cells
   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
      logic hit_here, set_stb, clr_stb;

      assign hit_here = bus_wr && dec_hit && (dec_idx == IDX_W'(i / 32))
                        && bus_wdata[i % 32] && wr_ok[i];
      assign set_stb  = hit_here && (dec_win == WIN_SET);
      assign clr_stb  = hit_here && (dec_win == WIN_CLR);

      irqp_cell u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .sync_line (line_s[i]),
         .rise      (line_rise[i]),
         .edge_mode (irq_edge_cfg[i]),
         .set_stb   (set_stb),
         .clr_stb   (clr_stb),
         .ack       (ack[i]),
         .eoi       (eoi[i]),
         .pend      (pend_o[i]),
         .active    (active_o[i])
      );

      // R8: a blocked non-secure read of a secure interrupt returns zero
      assert_ns_hidden_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (dec_hit && dec_idx == IDX_W'(i / 32) && sec_en && bus_ns
          && irq_secure_grp[i] && !irq_ns_allow[i]) |-> !bus_rdata[i % 32]);
   end

   // Read path: zero-extended pending view, one word selected
   logic [NBIT-1:0] vis_full;

   assign vis_full  = NBIT'(pend_o & rd_ok);
   assign bus_rdata = dec_hit ? vis_full[32*int'(dec_idx) +: 32] : '0;

   // R7: any address outside the implemented windows reads zero
   assert_unmapped_rdz_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_hit |-> (bus_rdata == '0));

endmodule

// File: tb/sim_irq_pend_bank.sv
`timescale 1ns/1ps
module sim_irq_pend_bank;

   localparam int N   = 48;
   localparam int SB  = 'h100;
   localparam int CB  = 'h180;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_line = '0, irq_edge_cfg = '1, irq_secure_grp = '0, irq_ns_allow = '0;
   logic          sec_en = 1'b0;
   logic [N-1:0]  ack = '0, eoi = '0;
   logic          bus_wr = 1'b0;
   logic [11:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic          bus_ns = 1'b0;
   logic [31:0]   bus_rdata;
   logic [N-1:0]  pend_o, active_o;

   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   irq_pend_bank #(
      .REGS_M1(1), .NUM_IRQ(N), .SGI_NUM(16), .SYNC_STAGES(2),
      .ADDR_W(12), .SET_BASE(SB), .CLR_BASE(CB)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .irq_line(irq_line), .irq_edge_cfg(irq_edge_cfg),
      .irq_secure_grp(irq_secure_grp), .irq_ns_allow(irq_ns_allow), .sec_en(sec_en),
      .ack(ack), .eoi(eoi), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_ns(bus_ns), .bus_rdata(bus_rdata), .pend_o(pend_o), .active_o(active_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick(input int n = 1);
      repeat (n) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic wr(input int addr, input logic [31:0] data, input logic ns = 1'b0);
      bus_addr  = 12'(addr);
      bus_wdata = data;
      bus_ns    = ns;
      bus_wr    = 1'b1;
      tick();
      bus_wr    = 1'b0;
      bus_wdata = '0;
   endtask

   task automatic rd(input int addr, output logic [31:0] data, input logic ns = 1'b0);
      bus_addr = 12'(addr);
      bus_ns   = ns;
      #1;
      data = bus_rdata;
   endtask

   task automatic pulse(input int i);
      irq_line[i] = 1'b1;
      tick(3);
      irq_line[i] = 1'b0;
      tick(4);
   endtask

   task automatic do_ack(input int i);
      ack[i] = 1'b1;
      tick();
      ack[i] = 1'b0;
   endtask

   task automatic do_eoi(input int i);
      eoi[i] = 1'b1;
      tick();
      eoi[i] = 1'b0;
   endtask

   initial begin
      #(5.0 * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [31:0] d;
      tick(3);
      rst_n = 1'b1;
      tick();

      // R10: reset state
      rd(CB, d);       chk("R10 clr0", d, 32'h0);
      rd(CB + 4, d);   chk("R10 clr1", d, 32'h0);
      rd(SB, d);       chk("R10 set0", d, 32'h0);
      chk("R10 pend", 32'(pend_o == '0), 32'h1);
      chk("R10 active", 32'(active_o == '0), 32'h1);

      // R1 R5 R6 R3: sweep all implemented interrupts with an edge pulse and a clear
      for (int i = 0; i < N; i++) begin
         logic [31:0] bit_m;
         int          r;
         bit_m = 32'h1 << (i % 32);
         r     = i / 32;
         pulse(i);
         rd(CB + 4*r, d); chk("R1 R5 clr-window map", d, bit_m);
         rd(SB + 4*r, d); chk("R1 set-window alias", d, bit_m);
         wr(CB + 4*r, bit_m);
         rd(CB + 4*r, d);
         if (i < 16) begin
            chk("R6 sgi clear ignored", d, bit_m);
            do_ack(i);
            chk("R9 sgi ack active", 32'(active_o[i]), 32'h1);
            do_eoi(i);
            rd(CB + 4*r, d); chk("R9 sgi after eoi", d, 32'h0);
         end else begin
            chk("R3 edge clear", d, 32'h0);
         end
      end

      // R11 R6 R7 R3: full-word set and clear masks
      wr(SB, 32'hFFFF_FFFF);
      rd(CB, d);      chk("R11 R6 set reg0", d, 32'hFFFF_0000);
      wr(SB + 4, 32'hFFFF_FFFF);
      rd(CB + 4, d);  chk("R7 unimpl bits zero", d, 32'h0000_FFFF);
      wr(CB + 4, 32'h0);
      rd(CB + 4, d);  chk("R3 zero write no effect", d, 32'h0000_FFFF);
      wr(CB, 32'h00FF_0000);
      rd(CB, d);      chk("R3 partial clear", d, 32'hFF00_0000);
      wr(CB, 32'hFFFF_FFFF);
      wr(CB + 4, 32'hFFFF_FFFF);
      rd(CB, d);      chk("R3 clear all reg0", d, 32'h0);
      rd(CB + 4, d);  chk("R3 clear all reg1", d, 32'h0);

      // R4: level-triggered interrupt 40 (register 1 bit 8)
      irq_edge_cfg[40] = 1'b0;
      irq_line[40] = 1'b1;
      tick(4);
      rd(CB + 4, d);  chk("R4 level high pending", d, 32'h100);
      wr(CB + 4, 32'h100);
      rd(CB + 4, d);  chk("R4 clear with line high", d, 32'h100);
      irq_line[40] = 1'b0;
      tick(4);
      rd(CB + 4, d);  chk("R4 line low idle", d, 32'h0);
      wr(SB + 4, 32'h100);
      rd(CB + 4, d);  chk("R11 level set latch", d, 32'h100);
      wr(CB + 4, 32'h100);
      rd(CB + 4, d);  chk("R4 clear latch", d, 32'h0);
      wr(SB + 4, 32'h100);
      irq_line[40] = 1'b1;
      tick(4);
      irq_line[40] = 1'b0;
      tick(4);
      rd(CB + 4, d);  chk("R4 latch outlives line", d, 32'h100);
      irq_line[40] = 1'b1;
      tick(4);
      wr(CB + 4, 32'h100);
      rd(CB + 4, d);  chk("R4 latch cleared line holds", d, 32'h100);
      irq_line[40] = 1'b0;
      tick(4);
      rd(CB + 4, d);  chk("R4 both gone", d, 32'h0);
      irq_edge_cfg[40] = 1'b1;

      // R2 R3 R9: active and active-and-pending on interrupt 20
      pulse(20);
      do_ack(20);
      chk("R9 ack active", 32'(active_o[20]), 32'h1);
      chk("R9 ack removes pending", 32'(pend_o[20]), 32'h0);
      rd(CB, d);      chk("R2 active only reads 0", d, 32'h0);
      wr(CB, 32'h0010_0000);
      chk("R3 clear on active only", 32'(active_o[20]), 32'h1);
      pulse(20);
      rd(CB, d);      chk("R2 active and pending reads 1", d, 32'h0010_0000);
      wr(CB, 32'h0010_0000);
      rd(CB, d);      chk("R3 active-pending to active", d, 32'h0);
      chk("R3 stays active", 32'(active_o[20]), 32'h1);
      do_eoi(20);
      chk("R9 eoi inactive", 32'(active_o[20]), 32'h0);

      // R8: security gating on interrupts 33 and 34 (register 1 bits 1, 2)
      sec_en = 1'b1;
      irq_secure_grp[33] = 1'b1;
      irq_secure_grp[34] = 1'b1;
      wr(SB + 4, 32'h2);
      rd(CB + 4, d, 1'b1); chk("R8 ns read hidden", d, 32'h0);
      rd(CB + 4, d);       chk("R8 secure read", d, 32'h2);
      wr(CB + 4, 32'h2, 1'b1);
      rd(CB + 4, d);       chk("R8 ns clear ignored", d, 32'h2);
      wr(SB + 4, 32'h4, 1'b1);
      rd(CB + 4, d);       chk("R8 ns set ignored", d, 32'h2);
      irq_ns_allow[33] = 1'b1;
      rd(CB + 4, d, 1'b1); chk("R8 permitted ns read", d, 32'h2);
      wr(CB + 4, 32'h2, 1'b1);
      rd(CB + 4, d);       chk("R8 permitted ns clear", d, 32'h0);
      sec_en = 1'b0;
      wr(SB + 4, 32'h4, 1'b1);
      rd(CB + 4, d, 1'b1); chk("R8 security off ns set", d, 32'h4);
      wr(CB + 4, 32'h4, 1'b1);
      rd(CB + 4, d);       chk("R8 security off ns clear", d, 32'h0);
      irq_secure_grp = '0;
      irq_ns_allow = '0;

      // R7: unmapped offsets
      wr(SB, 32'h0010_0000);
      rd(CB + 8, d);  chk("R7 clr index beyond", d, 32'h0);
      rd(SB + 8, d);  chk("R7 set index beyond", d, 32'h0);
      rd(0, d);       chk("R7 outside windows", d, 32'h0);
      wr(CB + 8, 32'hFFFF_FFFF);
      wr(0, 32'hFFFF_FFFF);
      rd(CB, d);      chk("R7 unmapped writes ignored", d, 32'h0010_0000);
      wr(CB, 32'hFFFF_FFFF);
      rd(CB, d);      chk("R3 final clear", d, 32'h0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule